// File: doc/BRIEF.md
# Breaker Failure Detection Controller

This block decides that a circuit breaker has failed to clear a fault after protection has asked it to trip. Once a trip is initiated, three delay paths run side by side. Each path has its own enable and its own delay. The early path needs the breaker's auxiliary contact to still report "closed" and fault current to be present. The main path ignores the contact and looks only at current. The slow path has no current check and needs the contact closed with the breaker marked in service. When any enabled path operates, a backup trip is declared and held for a programmable seal-in time. A separate re-trip output follows the initiate request.

All timing counts a sampling tick, meant to arrive every 1/8 of a power cycle. Every delay is a count of ticks. The current levels arrive as two comparator flags, high-set and low-set. The early and main paths check the high-set flag when their timer expires. After a further delay, equal to the expected breaker opening time, they check the low-set flag instead. Because the flags are only looked at after the delay, slow-resetting detectors are acceptable.

Top module: `brkfail_ctrl`

## Requirements
- R1: A synchronous reset, applied on any clock, clears every timer, `retrip`, `path_op` and `bf_trip` to 0 on the following edge.
- R2: State and outputs change only on clock edges where `tick` is 1. On other edges every output holds its value.
- R3: On each tick, `retrip` takes the value of `initiate`.
- R4: The timer of path p (bit p of `path_en`; bit 0 = early, bit 1 = main, bit 2 = slow) runs while `initiate` and its enable are both 1. It expires on the (D+1)th such consecutive tick, where D is the path's delay setting. Any tick with `initiate` or the enable at 0 returns the path to idle, so it does not operate.
- R5: `path_op[0]` (early) is set on a tick when its timer has expired, `brk_closed` is 1 and the selected current flag is 1.
- R6: `path_op[1]` (main) is set on a tick when its timer has expired and the selected current flag is 1, whatever the value of `brk_closed`.
- R7: For the early and main paths, the selected current flag is `oc_high` from the expiry tick until `dly_open`+1 ticks after it. From that tick onward it is `oc_low`.
- R8: `path_op[2]` (slow) is set on a tick when its timer has expired, `brk_closed` is 1 and `in_service` is 1. It never looks at the current flags.
- R9: `bf_trip` goes to 1 on any tick where a `path_op` bit is set. It stays at 1 and falls on the (`dly_seal`+1)th later tick with no operating path. Any new operation restarts this hold count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sampling tick, one clock wide |
| initiate | input | 1 | Breaker-failure initiate request |
| brk_closed | input | 1 | Auxiliary contact, 1 = breaker closed |
| in_service | input | 1 | Control switch, 1 = breaker in service |
| oc_high | input | 1 | High-set overcurrent comparator flag |
| oc_low | input | 1 | Low-set overcurrent comparator flag |
| path_en | input | 3 | Enable per path (bit 0 early, 1 main, 2 slow) |
| dly_early | input | DLY_W | Early path delay, ticks |
| dly_main | input | DLY_W | Main path delay, ticks |
| dly_slow | input | DLY_W | Slow path delay, ticks |
| dly_open | input | DLY_W | Expected opening time before the switch to low-set, ticks |
| dly_seal | input | DLY_W | Seal-in hold time of the backup trip, ticks |
| retrip | output | 1 | Re-trip to the protected breaker |
| path_op | output | 3 | Per-path operate flags |
| bf_trip | output | 1 | Sealed-in backup trip |

## Verification
The bench aims at several edges. The expiry tick must be exact: an off-by-one counter operates a tick early or late. The switch from high-set to low-set supervision is checked with only one flag asserted at a time, so a design that never switches, or switches at expiry, loses or gains operations. Dropping `initiate` or an enable in mid-count must leave the path idle, otherwise stale counts fire early on the next initiate. The slow path is driven with the breaker out of service and with current absent. The seal-in is checked for both restart and expiry, where a counter that does not restart drops the trip while paths still operate.

// File: rtl/brkfail_pkg.sv
package brkfail_pkg;
    parameter int unsigned BF_DLY_W = 16;
    parameter int unsigned BF_NPATH = 3;

    typedef enum logic [1:0] {
        PATH_EARLY = 2'd0,
        PATH_MAIN  = 2'd1,
        PATH_SLOW  = 2'd2
    } bf_path_e;
endpackage

// File: rtl/bf_path_timer.sv
module bf_path_timer #(
    parameter int unsigned W      = 16,
    parameter bit          SUPERV = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic [W-1:0] dly,
    input  logic [W-1:0] open_dly,
    output logic         exp_nxt,
    output logic         low_nxt
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] sup;
        logic         expd;
        logic         low;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (!run) begin
                s_d = '0;
            end else if (!s_q.expd) begin
                if (s_q.cnt == dly) s_d.expd = 1'b1;
                else                s_d.cnt  = s_q.cnt + 1'b1;
            end else if (SUPERV && !s_q.low) begin
                if (s_q.sup == open_dly) s_d.low = 1'b1;
                else                     s_d.sup = s_q.sup + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign exp_nxt = s_d.expd;
    assign low_nxt = s_d.low;
endmodule

// File: rtl/bf_seal_in.sv
module bf_seal_in #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         decl,
    input  logic [W-1:0] seal_dly,
    output logic         trip
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         act;
    } seal_t;

    seal_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (decl) begin
                s_d.act = 1'b1;
                s_d.cnt = '0;
            end else if (s_q.act) begin
                if (s_q.cnt == seal_dly) begin
                    s_d.act = 1'b0;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign trip = s_q.act;
endmodule

// File: rtl/brkfail_ctrl.sv
module brkfail_ctrl
    import brkfail_pkg::*;
#(
    parameter int unsigned DLY_W = BF_DLY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             initiate,
    input  logic             brk_closed,
    input  logic             in_service,
    input  logic             oc_high,
    input  logic             oc_low,
    input  logic [2:0]       path_en,
    input  logic [DLY_W-1:0] dly_early,
    input  logic [DLY_W-1:0] dly_main,
    input  logic [DLY_W-1:0] dly_slow,
    input  logic [DLY_W-1:0] dly_open,
    input  logic [DLY_W-1:0] dly_seal,
    output logic             retrip,
    output logic [2:0]       path_op,
    output logic             bf_trip
);
    localparam int unsigned NP   = BF_NPATH;
    localparam int          I_EA = int'(PATH_EARLY);
    localparam int          I_SL = int'(PATH_SLOW);

    typedef struct packed {
        logic          retrip;
        logic [NP-1:0] op;
    } out_t;

    out_t r_d, r_q;

    logic [DLY_W-1:0] dly_sel [NP];
    logic [NP-1:0]    exp_n;
    logic [NP-1:0]    low_n;
    logic [NP-1:0]    cond;
    logic             decl;

    assign dly_sel[I_EA]            = dly_early;
    assign dly_sel[int'(PATH_MAIN)] = dly_main;
    assign dly_sel[I_SL]            = dly_slow;

    for (genvar p = 0; p < NP; p++) begin : g_path
        bf_path_timer #(
            .W      (DLY_W),
            .SUPERV (p != I_SL)
        ) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .run      (initiate && path_en[p]),
            .dly      (dly_sel[p]),
            .open_dly (dly_open),
            .exp_nxt  (exp_n[p]),
            .low_nxt  (low_n[p])
        );

        if (p == I_SL) begin : g_slow
            assign cond[p] = brk_closed && in_service;
        end else if (p == I_EA) begin : g_early
            assign cond[p] = brk_closed && (low_n[p] ? oc_low : oc_high);
        end else begin : g_main
            assign cond[p] = low_n[p] ? oc_low : oc_high;
        end
    end

    always_comb begin
        r_d = r_q;
        if (tick) begin
            r_d.retrip = initiate;
            r_d.op     = exp_n & cond;
        end
    end

    assign decl = tick && |(exp_n & cond);

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    bf_seal_in #(.W(DLY_W)) u_seal (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .decl     (decl),
        .seal_dly (dly_seal),
        .trip     (bf_trip)
    );

    assign retrip  = r_q.retrip;
    assign path_op = r_q.op;
endmodule

// File: rtl/brkfail_ctrl_chk.sv
module brkfail_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       initiate,
    input logic       brk_closed,
    input logic       in_service,
    input logic [2:0] path_op,
    input logic       retrip,
    input logic       bf_trip
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!retrip && path_op == 3'b000 && !bf_trip));

    a_r2_hold_off_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable({retrip, path_op, bf_trip}));

    a_r3_retrip_follows: assert property (@(posedge clk) disable iff (rst)
        tick |=> (retrip == $past(initiate)));

    a_r4_idle_without_initiate: assert property (@(posedge clk) disable iff (rst)
        (tick && !initiate) |=> (path_op == 3'b000));

    a_r5_early_needs_closed: assert property (@(posedge clk) disable iff (rst)
        tick |=> (!path_op[0] || $past(brk_closed)));

    a_r8_slow_needs_service: assert property (@(posedge clk) disable iff (rst)
        tick |=> (!path_op[2] || $past(brk_closed && in_service)));

    a_r9_trip_with_op: assert property (@(posedge clk) disable iff (rst)
        (path_op != 3'b000) |-> bf_trip);
endmodule

bind brkfail_ctrl brkfail_ctrl_chk u_chk (.*);

// File: tb/test_brkfail_ctrl.sv
module test_brkfail_ctrl;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         initiate = 1'b0;
    logic         brk_closed = 1'b0;
    logic         in_service = 1'b0;
    logic         oc_high = 1'b0;
    logic         oc_low = 1'b0;
    logic [2:0]   path_en = 3'b000;
    logic [W-1:0] dly_early = 3, dly_main = 6, dly_slow = 12;
    logic [W-1:0] dly_open = 4, dly_seal = 5;
    logic         retrip;
    logic [2:0]   path_op;
    logic         bf_trip;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;

    // reference model state
    int  n_run [3];
    int  since = 0;
    bit  m_ret = 0, m_trip = 0;
    bit [2:0] m_op = 0;

    always #5 clk = ~clk;

    brkfail_ctrl i_brkfail_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .initiate(initiate),
        .brk_closed(brk_closed), .in_service(in_service),
        .oc_high(oc_high), .oc_low(oc_low), .path_en(path_en),
        .dly_early(dly_early), .dly_main(dly_main), .dly_slow(dly_slow),
        .dly_open(dly_open), .dly_seal(dly_seal),
        .retrip(retrip), .path_op(path_op), .bf_trip(bf_trip)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d act=%0h exp=%0h", req, cycle, act, exp);
        end
    endtask

    function automatic int dly_of(input int p);
        return (p == 0) ? int'(dly_early) : (p == 1) ? int'(dly_main) : int'(dly_slow);
    endfunction

    // behavioural model of one clock edge, using the inputs held across it
    task automatic model_edge();
        bit ex, lo, cur, any;
        if (rst) begin
            foreach (n_run[p]) n_run[p] = 0;
            since = 0; m_ret = 0; m_trip = 0; m_op = 0;
        end else if (tick) begin
            m_ret = initiate;
            for (int p = 0; p < 3; p++) begin
                if (initiate && path_en[p]) n_run[p]++;
                else                        n_run[p] = 0;
                ex  = n_run[p] >= dly_of(p) + 1;
                lo  = (p < 2) && ex && (n_run[p] - (dly_of(p) + 1) >= int'(dly_open) + 1);
                cur = lo ? oc_low : oc_high;
                case (p)
                    0:       m_op[p] = ex && brk_closed && cur;
                    1:       m_op[p] = ex && cur;
                    default: m_op[p] = ex && brk_closed && in_service;
                endcase
            end
            any = |m_op;
            if (any) begin
                m_trip = 1; since = 0;
            end else if (m_trip) begin
                since++;
                if (since > int'(dly_seal)) m_trip = 0;
            end
        end
    endtask

    task automatic clk1();
        bit was_rst, was_tick;
        was_rst  = rst;
        was_tick = tick;
        @(posedge clk);
        #2;
        model_edge();
        if (was_rst) begin
            check(!retrip && path_op == 0 && !bf_trip, "R1 reset",
                  {retrip, path_op, bf_trip}, 0);
        end else if (!was_tick) begin
            check({retrip, path_op, bf_trip} == {m_ret, m_op, m_trip}, "R2 hold",
                  {retrip, path_op, bf_trip}, {m_ret, m_op, m_trip});
        end else begin
            check(retrip == m_ret, "R3 retrip", retrip, m_ret);
            check(path_op[0] == m_op[0], "R4 R5 R7 early path", path_op[0], m_op[0]);
            check(path_op[1] == m_op[1], "R4 R6 R7 main path", path_op[1], m_op[1]);
            check(path_op[2] == m_op[2], "R4 R8 slow path", path_op[2], m_op[2]);
            check(bf_trip == m_trip, "R9 seal-in trip", bf_trip, m_trip);
        end
        cycle++;
        tick = (cycle % 3 == 0);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) clk1();
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        foreach (n_run[p]) n_run[p] = 0;
        rst = 1'b1;
        run(4);
        rst = 1'b0;
        path_en = 3'b111; brk_closed = 1; in_service = 1;
        // R5 R6: current on high-set only, breaker stays closed
        initiate = 1; oc_high = 1;
        run(30);
        // R7: after the switch, only the low-set flag counts
        oc_high = 0; oc_low = 1;
        run(30);
        oc_high = 1; oc_low = 0;
        run(15);
        // R4: initiate falls mid-run, then restarts
        initiate = 0;
        run(9);
        initiate = 1;
        run(8);
        initiate = 0;
        run(40);
        // R6: breaker open but current flowing, only main path
        brk_closed = 0; oc_high = 1; oc_low = 1; initiate = 1;
        run(60);
        // R8: no current, closed, out of service then in service
        initiate = 0; run(6);
        brk_closed = 1; oc_high = 0; oc_low = 0; in_service = 0; initiate = 1;
        run(60);
        in_service = 1;
        run(30);
        // R4: slow path disabled mid-run
        path_en = 3'b011;
        run(60);
        initiate = 0;
        run(40);
        // R9: seal-in expiry with seal 0
        rst = 1; dly_seal = 0; run(2); rst = 0;
        initiate = 1; oc_high = 1; path_en = 3'b010;
        run(30);
        oc_high = 0; oc_low = 0;
        run(20);
        initiate = 0;
        run(10);
        // randomised segments
        for (int s = 0; s < 20; s++) begin
            rst = 1;
            dly_early = $urandom_range(0, 4);
            dly_main  = $urandom_range(0, 8);
            dly_slow  = $urandom_range(0, 14);
            dly_open  = $urandom_range(0, 5);
            dly_seal  = $urandom_range(0, 6);
            run(2);
            rst = 0;
            for (int c = 0; c < 300; c++) begin
                if ($urandom_range(0, 39) == 0) initiate   = ~initiate;
                if ($urandom_range(0, 9)  == 0) brk_closed = ~brk_closed;
                if ($urandom_range(0, 19) == 0) in_service = ~in_service;
                if ($urandom_range(0, 7)  == 0) oc_high    = ~oc_high;
                if ($urandom_range(0, 7)  == 0) oc_low     = ~oc_low;
                if ($urandom_range(0, 49) == 0) path_en    = 3'($urandom_range(0, 7));
                clk1();
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule